// File: doc/BRIEF.md
# Indexed I/O Port Configuration Backdoor Detector

This block sits in the path between a host and a device that share two legacy I/O ports: a command port and a data port. It watches every access that crosses the pair and tracks a short command sequence. The sequence first arms the detector, then loads a target offset through the data port, then names a direction. If the loaded offset falls inside a 256-entry configuration mirror, the next data-port access in that direction is served from a local shadow configuration space instead of the device. A data-port read in this case still reaches the device, but the shadow word replaces the value it returns. A data-port write in this case is kept from the device and goes to the shadow only.

Every other access goes to the device unchanged. Any access that breaks the sequence sends the detector back to idle. A redirected access also ends the sequence, so each opening grants exactly one access.

The host side uses a valid/ready request. A request is accepted in the cycle where both `req_valid` and `req_ready` are high. When the request goes to the device, `req_ready` follows `dev_ready`. When the request is a shadow-only write, `req_ready` is high. A request that is not accepted leaves the sequencer unchanged. While it waits, the host must hold the request stable. Read data returns in the same cycle on `rsp_rdata`. The shadow space is outside this block: it is read combinationally at `shadow_addr` and written with the `shadow_we` strobe.

Top module: `ioport_backdoor_snoop`

## Requirements
- R1: After reset the sequencer is idle. A data write followed by command 0x0538 and a data read returns the device value.
- R2: An accepted access that is not one of the transitions in R3, R4 and R5 returns the sequencer to idle. Examples are 0x0338 while armed, a data read while opened, and a data read in the write stage.
- R3: An accepted command write of 0x0338, compared across all 16 bits, moves an idle sequencer to armed. A value such as 0x1338 does not.
- R4: An accepted data write while armed latches the written 16-bit value as the offset and opens the window. The write is still forwarded to the device.
- R5: Command writes are always forwarded to the device. In the opened state, 0x0538 selects the read stage and 0x0738 selects the write stage.
- R6: In the read stage, an offset whose bits 15..8 equal 0x18 makes the data read return `shadow_rdata`, with `shadow_addr` set to offset bits 7..0. The device is still accessed. An offset outside that range returns `dev_rdata`.
- R7: In the write stage with an in-range offset, a data write asserts `shadow_we` with the write data and address. `dev_valid` stays low and `req_ready` is high regardless of `dev_ready`.
- R8: A command read is forwarded and returns the sequencer to idle.
- R9: A request held with `req_ready` low does not change the sequencer. For a forwarded request, `req_ready` equals `dev_ready`.
- R10: A redirected access ends the sequence. The next data access of the same kind goes to the device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host access request valid |
| req_ready | output | 1 | Host access accepted this cycle |
| req_is_data | input | 1 | 1 = data port, 0 = command port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Host write data |
| rsp_rdata | output | 16 | Read data returned to host |
| dev_valid | output | 1 | Access forwarded to device |
| dev_ready | input | 1 | Device accepts forwarded access |
| dev_is_data | output | 1 | Forwarded port select |
| dev_write | output | 1 | Forwarded direction |
| dev_wdata | output | 16 | Forwarded write data |
| dev_rdata | input | 16 | Device read data |
| shadow_addr | output | 8 | Shadow space index |
| shadow_we | output | 1 | Shadow write strobe |
| shadow_wdata | output | 16 | Shadow write data |
| shadow_rdata | input | 16 | Shadow read data |

## Verification
The full read sequence and the full write sequence are both run. Each is followed by a repeat access, which separates a one-shot opening from one that stays open. Near-miss patterns each test one break in the chain:
- an offset just outside the mirror;
- a command value that differs only in its upper bits;
- a repeated arm command;
- a command-port read in the middle of the sequence;
- a direction mismatch.
Each of these separates correct redirect decisions from ones that are too loose. Device back-pressure is applied in the middle of the sequence, which shows whether a stalled request wrongly advances the state.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ARMED = 3'd1,
    SQ_OPEN  = 3'd2,
    SQ_RDGO  = 3'd3,
    SQ_WRGO  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/bd_seq_fsm.sv
module bd_seq_fsm
  import bd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] CMD_ARM = 16'h0338,
  parameter logic [DATA_W-1:0] CMD_RD  = 16'h0538,
  parameter logic [DATA_W-1:0] CMD_WR  = 16'h0738
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              is_data,
  input  logic              is_write,
  input  logic [DATA_W-1:0] wdata,
  output seq_st_t           state,
  output logic              latch_en
);
  seq_st_t nxt;

  always_comb begin
    nxt = state;
    if (acc) begin
      nxt = SQ_IDLE;
      if (!is_data && is_write) begin
        if (wdata == CMD_ARM && state == SQ_IDLE)     nxt = SQ_ARMED;
        else if (wdata == CMD_RD && state == SQ_OPEN) nxt = SQ_RDGO;
        else if (wdata == CMD_WR && state == SQ_OPEN) nxt = SQ_WRGO;
      end else if (is_data && is_write && state == SQ_ARMED) begin
        nxt = SQ_OPEN;
      end
    end
  end

  assign latch_en = acc && is_data && is_write && (state == SQ_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/bd_offset_latch.sv
module bd_offset_latch #(
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 8,
  parameter logic [DATA_W-1:0] WIN_BASE = 16'h1800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_W-1:0]   din,
  output logic                in_range,
  output logic [WIN_BITS-1:0] win_idx
);
  localparam int HI_W = DATA_W - WIN_BITS;
  localparam logic [HI_W-1:0] BASE_HI = WIN_BASE[DATA_W-1:WIN_BITS];

  logic [DATA_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (load) off_q <= din;
  end

  assign in_range = (off_q[DATA_W-1:WIN_BITS] == BASE_HI);
  assign win_idx  = off_q[WIN_BITS-1:0];
endmodule

// File: rtl/bd_redirect_mux.sv
module bd_redirect_mux
  import bd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  seq_st_t           state,
  input  logic              in_range,
  input  logic              req_valid,
  input  logic              req_is_data,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              dev_ready,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic [DATA_W-1:0] shadow_rdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dev_valid,
  output logic              shadow_we,
  output logic [DATA_W-1:0] shadow_wdata
);
  logic rd_hit, wr_hit;

  assign rd_hit = (state == SQ_RDGO) && in_range && req_is_data && !req_write;
  assign wr_hit = (state == SQ_WRGO) && in_range && req_is_data && req_write;

  assign dev_valid    = req_valid && !wr_hit;
  assign req_ready    = wr_hit ? 1'b1 : dev_ready;
  assign rsp_rdata    = rd_hit ? shadow_rdata : dev_rdata;
  assign shadow_we    = req_valid && wr_hit;
  assign shadow_wdata = req_wdata;
endmodule

// File: rtl/ioport_backdoor_snoop.sv
module ioport_backdoor_snoop
  import bd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WIN_BITS = 8,
  parameter logic [DATA_W-1:0] WIN_BASE = 16'h1800,
  parameter logic [DATA_W-1:0] CMD_ARM  = 16'h0338,
  parameter logic [DATA_W-1:0] CMD_RD   = 16'h0538,
  parameter logic [DATA_W-1:0] CMD_WR   = 16'h0738
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_is_data,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                dev_valid,
  input  logic                dev_ready,
  output logic                dev_is_data,
  output logic                dev_write,
  output logic [DATA_W-1:0]   dev_wdata,
  input  logic [DATA_W-1:0]   dev_rdata,
  output logic [WIN_BITS-1:0] shadow_addr,
  output logic                shadow_we,
  output logic [DATA_W-1:0]   shadow_wdata,
  input  logic [DATA_W-1:0]   shadow_rdata
);
  seq_st_t cur_st;
  logic    latch_en;
  logic    in_range;
  logic    acc;

  assign acc = req_valid && req_ready;

  bd_seq_fsm #(
    .DATA_W(DATA_W), .CMD_ARM(CMD_ARM), .CMD_RD(CMD_RD), .CMD_WR(CMD_WR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_data(req_is_data),
    .is_write(req_write), .wdata(req_wdata), .state(cur_st), .latch_en(latch_en)
  );

  bd_offset_latch #(
    .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .load(latch_en), .din(req_wdata),
    .in_range(in_range), .win_idx(shadow_addr)
  );

  bd_redirect_mux #(.DATA_W(DATA_W)) u_mux (
    .state(cur_st), .in_range(in_range), .req_valid(req_valid),
    .req_is_data(req_is_data), .req_write(req_write), .req_wdata(req_wdata),
    .dev_ready(dev_ready), .dev_rdata(dev_rdata), .shadow_rdata(shadow_rdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .dev_valid(dev_valid),
    .shadow_we(shadow_we), .shadow_wdata(shadow_wdata)
  );

  assign dev_is_data = req_is_data;
  assign dev_write   = req_write;
  assign dev_wdata   = req_wdata;
endmodule

// File: rtl/bd_snoop_chk.sv
module bd_snoop_chk
  import bd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] CMD_ARM = 16'h0338
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_data,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              dev_valid,
  input logic              shadow_we,
  input seq_st_t           cur_st
);
  // R7
  shadow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> (!dev_valid && req_ready));

  // R5
  cmd_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_data) |-> dev_valid);

  // R8
  cmd_rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_is_data && !req_write) |=> (cur_st == SQ_IDLE));

  // R2
  data_rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_is_data && !req_write) |=> (cur_st == SQ_IDLE));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(cur_st));

  // R3
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_is_data && req_write &&
     req_wdata == CMD_ARM && cur_st == SQ_IDLE) |=> (cur_st == SQ_ARMED));

  // R10
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |=> (cur_st == SQ_IDLE));
endmodule

bind ioport_backdoor_snoop bd_snoop_chk #(.DATA_W(DATA_W), .CMD_ARM(CMD_ARM)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_data(req_is_data), .req_write(req_write), .req_wdata(req_wdata),
  .dev_valid(dev_valid), .shadow_we(shadow_we), .cur_st(cur_st)
);

// File: tb/ioport_backdoor_snoop_tb.sv
`timescale 1ns/1ps
module ioport_backdoor_snoop_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_data = 1'b0, req_write = 1'b0;
  logic [15:0] req_wdata = '0, dev_rdata = '0, shadow_rdata = '0;
  logic dev_ready = 1'b1;
  logic req_ready, dev_valid, dev_is_data, dev_write, shadow_we;
  logic [15:0] rsp_rdata, dev_wdata, shadow_wdata;
  logic [7:0] shadow_addr;

  int errors = 0;
  int checks = 0;
  int mst = 0;               // 0 idle 1 armed 2 open 3 read 4 write
  logic [15:0] moff = '0;
  int seed = 16'h0100;

  always #2.5 clk = ~clk;

  ioport_backdoor_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .dev_valid(dev_valid), .dev_ready(dev_ready),
    .dev_is_data(dev_is_data), .dev_write(dev_write), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .shadow_addr(shadow_addr), .shadow_we(shadow_we),
    .shadow_wdata(shadow_wdata), .shadow_rdata(shadow_rdata)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive on negedge, compare before next posedge, advance model after it.
  task automatic cyc(input string tag, input logic v, input logic d, input logic w,
                     input logic [15:0] wd, input logic drdy);
    bit inr, rdh, wrh, e_rdy, accd;
    @(negedge clk);
    seed = seed + 7;
    req_valid = v; req_is_data = d; req_write = w; req_wdata = wd;
    dev_ready = drdy; dev_rdata = 16'hD000 ^ 16'(seed); shadow_rdata = 16'h5A00 ^ 16'(seed);
    #1;
    inr = (moff[15:8] == 8'h18);
    rdh = (mst == 3) && d && !w && inr;
    wrh = (mst == 4) && d && w && inr;
    e_rdy = wrh ? 1'b1 : drdy;
    chk(tag, "dev_valid", 16'(dev_valid), 16'(v && !wrh));
    chk(tag, "shadow_we", 16'(shadow_we), 16'(v && wrh));
    if (v) chk(tag, "req_ready", 16'(req_ready), 16'(e_rdy));
    if (v && !w) chk(tag, "rsp_rdata", rsp_rdata, rdh ? shadow_rdata : dev_rdata);
    if (v && (rdh || wrh)) chk(tag, "shadow_addr", 16'(shadow_addr), 16'(moff[7:0]));
    if (v && wrh) chk(tag, "shadow_wdata", shadow_wdata, wd);
    if (v && !wrh) chk(tag, "dev_wdata", dev_wdata, wd);
    accd = v && e_rdy;
    @(posedge clk);
    if (accd) begin
      if (!d && w && wd == 16'h0338 && mst == 0) mst = 1;
      else if (!d && w && wd == 16'h0538 && mst == 2) mst = 3;
      else if (!d && w && wd == 16'h0738 && mst == 2) mst = 4;
      else if (d && w && mst == 1) begin mst = 2; moff = wd; end
      else mst = 0;
    end
  endtask

  task automatic cw(input string tag, input logic [15:0] v); cyc(tag, 1, 0, 1, v, 1); endtask
  task automatic cr(input string tag); cyc(tag, 1, 0, 0, 16'h0, 1); endtask
  task automatic dw(input string tag, input logic [15:0] v); cyc(tag, 1, 1, 1, v, 1); endtask
  task automatic dr(input string tag); cyc(tag, 1, 1, 0, 16'h0, 1); endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset dev_valid", 16'(dev_valid), 16'h0);
    chk("R1", "reset shadow_we", 16'(shadow_we), 16'h0);
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 16'h0, 1);
    // R1: idle after reset, nothing opened
    dw("R1", 16'h1810); cw("R1", 16'h0538); dr("R1");
    // read backdoor
    cw("R3", 16'h0338); dw("R4", 16'h1842); cw("R5", 16'h0538); dr("R6");
    dr("R10");
    // write backdoor with device stalled
    cw("R3", 16'h0338); dw("R4", 16'h1805); cw("R5", 16'h0738);
    cyc("R7", 1, 1, 1, 16'hBEEF, 0);
    dw("R10", 16'h1234);
    // out of range offset
    cw("R3", 16'h0338); dw("R6", 16'h1905); cw("R5", 16'h0538); dr("R6");
    cw("R3", 16'h0338); dw("R6", 16'h17FF); cw("R5", 16'h0538); dr("R6");
    // full 16-bit command compare
    cw("R3", 16'h1338); dw("R3", 16'h1810); cw("R3", 16'h0538); dr("R3");
    // repeated arm breaks sequence
    cw("R2", 16'h0338); cw("R2", 16'h0338); dw("R2", 16'h1810); cw("R2", 16'h0538); dr("R2");
    // command read breaks sequence
    cw("R8", 16'h0338); dw("R8", 16'h1820); cr("R8"); cw("R8", 16'h0538); dr("R8");
    // back-pressure mid sequence
    cyc("R9", 1, 0, 1, 16'h0338, 0); cyc("R9", 1, 0, 1, 16'h0338, 0);
    cw("R9", 16'h0338);
    cyc("R9", 1, 1, 1, 16'h1830, 0); dw("R9", 16'h1830);
    cyc("R9", 1, 0, 1, 16'h0538, 0); cw("R9", 16'h0538);
    cyc("R9", 1, 1, 0, 16'h0, 0); dr("R9");
    // direction mismatch
    cw("R2", 16'h0338); dw("R2", 16'h18A0); cw("R2", 16'h0738); dr("R2"); dw("R2", 16'h0001);
    cw("R2", 16'h0338); dw("R2", 16'h18A0); cw("R2", 16'h0538); dw("R2", 16'h0002); dr("R2");
    // write stage then idle cycle keeps state, then write hits
    cw("R5", 16'h0338); dw("R5", 16'h18FF); cw("R5", 16'h0738);
    cyc("R9", 0, 0, 0, 16'h0, 1);
    dw("R7", 16'hCAFE); dw("R10", 16'hCAFE);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule